// File: doc/BRIEF.md
# Audio DMA Channel Command Register Bank

This block holds the command registers for eight audio DMA channels behind a simple byte-wide register bus. Each channel owns one 8-bit register that carries a two-bit run-control field, a sample byte-order select and a hardwired transfer-direction flag. Software starts, pauses and stops a channel by writing the run-control code. The channel's control logic turns those writes into one-cycle strobes for the fetch engine: a pointer-load strobe when a channel is started from idle, and a stop strobe when a busy channel is shut down.

The fetch engine reports an end-of-table descriptor on a per-channel strobe. The bank then drops that channel back to idle on its own, so software sees the run field read 00 afterwards. A small helper reorders the bytes of a 16-bit sample according to the order bit of a selected channel. The helper lets the data path use one sample layout whatever byte order each channel is set to.

Top module: `dma_cmd_bank`

## Requirements
- R1: A register reads as bit 3 = direction, bit 2 = byte order, bits 1:0 = run field, with bits 7:4 always 0. A read at any address that maps to no channel returns 00h.
- R2: Channel n's register is at address 20h + 8·n (n = 0..7). The direction bit reads 1 for channels 1, 3 and 5 and 0 for the others, so those three reset to 08h and the rest reset to 00h.
- R3: Code 11 moves a running channel to paused, with the run field reading 11. On an idle or paused channel it has no effect. The run and paused status outputs follow the channel state.
- R4: Code 01 on an idle channel makes it run and raises its pointer-load strobe for exactly the cycle after the write. On a paused channel it resumes running with no strobe. On a running channel it changes nothing.
- R5: Code 00 on a running or paused channel makes it idle and raises its stop strobe for exactly the cycle after the write. On an idle channel it gives no strobe.
- R6: Code 10 leaves the channel state and the run field unchanged.
- R7: An end-of-table strobe forces the channel idle (run field 00) with no load or stop strobe. It wins over a run-field write to the same channel in the same cycle, but the byte-order bit of that write is still stored.
- R8: Writes to bits 7:4 and bit 3 are ignored. A write changes only the addressed channel. A write to an unmapped address changes nothing.
- R9: The sample helper passes the sample through unchanged when the selected channel's order bit is 0. When the bit is 1 it swaps the two bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| eot_evt | input | 8 | Per-channel end-of-table strobe |
| load_ptr | output | 8 | Per-channel pointer-load strobe |
| stop_pulse | output | 8 | Per-channel stop strobe |
| ch_running | output | 8 | Per-channel running status |
| ch_paused | output | 8 | Per-channel paused status |
| smp_ch | input | 3 | Channel whose order bit the sample helper uses |
| smp_in | input | 16 | Sample as laid out in memory, lower address in bits 7:0 |
| smp_out | output | 16 | Sample in native order |

## Verification
The bench drives every channel from each of its three states with each of the four run codes and both order values, with and without a write and with and without an end-of-table strobe in the same cycle. Each case is checked against a model kept in the bench. A design that emitted a load strobe on resume from pause, or let pause act on an idle channel, would show a strobe or a field of 11 where none is due. A design that let the write beat the end-of-table strobe would leave the channel running. After every step the bench reads back all eight registers, which exposes writes that leak into a neighbour or that change the direction or reserved bits. A sweep over all 256 addresses at reset exposes decode aliasing and wrong reset values.

// File: rtl/dmacb_pkg.sv
package dmacb_pkg;

   // Run-control codes as written by software
   typedef enum logic [1:0] {
      RC_OFF  = 2'b00,
      RC_GO   = 2'b01,
      RC_RSV  = 2'b10,
      RC_HOLD = 2'b11
   } run_code_e;

   // Channel state, encoded so that it equals the readable run field
   typedef enum logic [1:0] {
      CH_IDLE   = 2'b00,
      CH_RUN    = 2'b01,
      CH_PAUSED = 2'b11
   } ch_state_e;

   typedef struct packed {
      logic [3:0] rsvd;
      logic       dir;
      logic       order;
      logic [1:0] run;
   } cmd_reg_t;

endpackage

// File: rtl/dmacb_addr_dec.sv
module dmacb_addr_dec #(
   parameter int ADDR_W      = 8,
   parameter int NCH         = 8,
   parameter int BASE        = 32,
   parameter int STRIDE_LOG2 = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NCH-1:0]    sel_o
);

   localparam int STRIDE = 1 << STRIDE_LOG2;
   localparam int SPAN   = NCH * STRIDE;

   generate
      if (BASE + SPAN > (1 << ADDR_W)) begin : g_bad_span
         $error("register window exceeds the address space");
      end
      if ((BASE % STRIDE) != 0) begin : g_bad_align
         $error("base must be aligned to the channel stride");
      end
      if (NCH < 1) begin : g_bad_nch
         $error("at least one channel is required");
      end
   endgenerate

   for (genvar i = 0; i < NCH; i++) begin : g_sel
      localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(BASE + i * STRIDE);
      assign sel_o[i] = (addr_i == CH_ADDR);
   end

   always_comb begin
      AST_SEL_ONEHOT: assert ($onehot0(sel_o) || $isunknown(addr_i)); // R8
   end

endmodule

// File: rtl/dmacb_chan_ctrl.sv
module dmacb_chan_ctrl
   import dmacb_pkg::*;
#(
   parameter bit DIR = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  logic [7:0] wdata_i,
   input  logic       eot_i,
   output logic [7:0] reg_o,
   output logic       load_o,
   output logic       stop_o,
   output logic       run_o,
   output logic       pause_o,
   output logic       order_o
);

   cmd_reg_t  wr_word;
   run_code_e wr_code;
   ch_state_e st_q;
   logic      order_q;
   logic      load_q;
   logic      stop_q;

   assign wr_word = cmd_reg_t'(wdata_i);
   assign wr_code = run_code_e'(wr_word.run);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= CH_IDLE;
         order_q <= 1'b0;
         load_q  <= 1'b0;
         stop_q  <= 1'b0;
      end else begin
         load_q <= 1'b0;
         stop_q <= 1'b0;
         if (wr_i) begin
            order_q <= wr_word.order;
         end
         if (eot_i) begin
            st_q <= CH_IDLE;
         end else if (wr_i) begin
            case (wr_code)
               RC_OFF: begin
                  if (st_q != CH_IDLE) stop_q <= 1'b1;
                  st_q <= CH_IDLE;
               end
               RC_GO: begin
                  if (st_q == CH_IDLE) load_q <= 1'b1;
                  st_q <= CH_RUN;
               end
               RC_HOLD: begin
                  if (st_q == CH_RUN) st_q <= CH_PAUSED;
               end
               default: begin
                  st_q <= st_q;
               end
            endcase
         end
      end
   end

   always_comb begin
      reg_o = {4'b0000, DIR, order_q, st_q};
   end

   assign load_o  = load_q;
   assign stop_o  = stop_q;
   assign run_o   = (st_q == CH_RUN);
   assign pause_o = (st_q == CH_PAUSED);
   assign order_o = order_q;

   AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> $past(wr_i && wr_code == RC_GO && !eot_i)); // R4
   AST_LOAD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> run_o); // R4
   AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> ($past(st_q) != CH_IDLE && $past(wr_i && !eot_i))); // R5
   AST_EOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      eot_i |=> (!run_o && !pause_o && !load_o && !stop_o)); // R7
   AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wr_code == RC_RSV && !eot_i) |=> $stable(st_q)); // R6
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wr_code == RC_HOLD && !eot_i && st_q == CH_IDLE) |=> (st_q == CH_IDLE)); // R3
   AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_o && pause_o)); // R3

endmodule

// File: rtl/dmacb_swap.sv
module dmacb_swap #(
   parameter int SAMPLE_W = 16
) (
   input  logic                swap_i,
   input  logic [SAMPLE_W-1:0] data_i,
   output logic [SAMPLE_W-1:0] data_o
);

   localparam int NBYTES = SAMPLE_W / 8;

   generate
      if ((SAMPLE_W % 8) != 0 || NBYTES < 2) begin : g_bad_w
         $error("sample width must be a whole number of bytes, at least two");
      end
   endgenerate

   logic [SAMPLE_W-1:0] rev;

   for (genvar b = 0; b < NBYTES; b++) begin : g_rev
      assign rev[b*8 +: 8] = data_i[(NBYTES-1-b)*8 +: 8];
   end

   assign data_o = swap_i ? rev : data_i;

   always_comb begin
      AST_SWAP_LOW: assert (swap_i !== 1'b1 || data_o[7:0] == data_i[SAMPLE_W-1 -: 8]); // R9
   end

endmodule

// File: rtl/dma_cmd_bank.sv
module dma_cmd_bank
   import dmacb_pkg::*;
#(
   parameter int           NCH         = 8,
   parameter int           ADDR_W      = 8,
   parameter int           BASE        = 32,
   parameter int           STRIDE_LOG2 = 3,
   parameter logic [NCH-1:0] DIR_MASK  = 8'h2A,
   parameter int           SAMPLE_W    = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_wr,
   input  logic [7:0]              bus_wdata,
   output logic [7:0]              bus_rdata,
   input  logic [NCH-1:0]          eot_evt,
   output logic [NCH-1:0]          load_ptr,
   output logic [NCH-1:0]          stop_pulse,
   output logic [NCH-1:0]          ch_running,
   output logic [NCH-1:0]          ch_paused,
   input  logic [$clog2(NCH)-1:0]  smp_ch,
   input  logic [SAMPLE_W-1:0]     smp_in,
   output logic [SAMPLE_W-1:0]     smp_out
);

   localparam int CH_W = $clog2(NCH);

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("bank needs at least two channels");
      end
   endgenerate

   logic [NCH-1:0] sel;
   logic [7:0]     regs  [NCH];
   logic [NCH-1:0] order_vec;

   dmacb_addr_dec #(
      .ADDR_W      (ADDR_W),
      .NCH         (NCH),
      .BASE        (BASE),
      .STRIDE_LOG2 (STRIDE_LOG2)
   ) dec_i (
      .addr_i (bus_addr),
      .sel_o  (sel)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dmacb_chan_ctrl #(
         .DIR (DIR_MASK[i])
      ) ctl_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (bus_wr && sel[i]),
         .wdata_i (bus_wdata),
         .eot_i   (eot_evt[i]),
         .reg_o   (regs[i]),
         .load_o  (load_ptr[i]),
         .stop_o  (stop_pulse[i]),
         .run_o   (ch_running[i]),
         .pause_o (ch_paused[i]),
         .order_o (order_vec[i])
      );
   end

   always_comb begin
      bus_rdata = 8'h00;
      for (int i = 0; i < NCH; i++) begin
         if (sel[i]) bus_rdata = bus_rdata | regs[i];
      end
   end

   logic smp_swap;
   always_comb begin
      smp_swap = 1'b0;
      if (int'(smp_ch) < NCH) smp_swap = order_vec[smp_ch];
   end

   dmacb_swap #(
      .SAMPLE_W (SAMPLE_W)
   ) swap_i (
      .swap_i (smp_swap),
      .data_i (smp_in),
      .data_o (smp_out)
   );

   AST_RD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[7:4] == 4'h0); // R1
   AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> (bus_rdata == 8'h00)); // R1
   AST_LOAD_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (load_ptr & stop_pulse) == '0); // R5
   AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_ptr)); // R8

endmodule

// File: tb/dma_cmd_bank_tb_top.sv
module dma_cmd_bank_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] DIRM = 8'h2A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic [7:0]  eot_evt = 8'h00;
   logic [7:0]  load_ptr, stop_pulse, ch_running, ch_paused;
   logic [2:0]  smp_ch = 3'd0;
   logic [15:0] smp_in = 16'h0000;
   logic [15:0] smp_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_cmd_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eot_evt(eot_evt),
      .load_ptr(load_ptr), .stop_pulse(stop_pulse), .ch_running(ch_running),
      .ch_paused(ch_paused), .smp_ch(smp_ch), .smp_in(smp_in), .smp_out(smp_out)
   );

   int total = 0;
   int bad = 0;
   logic [1:0] m_st  [8];
   logic       m_ord [8];

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_reg(input int n);
      return {4'b0000, DIRM[n], m_ord[n], m_st[n]};
   endfunction

   task automatic read_all(input string req);
      for (int n = 0; n < 8; n++) begin
         bus_addr = 8'(32 + 8 * n);
         #1;
         chk(req, {8'h00, bus_rdata}, {8'h00, exp_reg(n)});
      end
   endtask

   task automatic step(input logic w, input int ch, input logic [7:0] d, input logic [7:0] e);
      logic [7:0] xl, xs, xr, xp;
      xl = '0; xs = '0;
      for (int n = 0; n < 8; n++) begin
         logic wn;
         wn = w && (n == ch);
         if (wn) m_ord[n] = d[2];
         if (e[n]) m_st[n] = 2'b00;
         else if (wn) begin
            case (d[1:0])
               2'b00: begin if (m_st[n] != 2'b00) xs[n] = 1'b1; m_st[n] = 2'b00; end
               2'b01: begin if (m_st[n] == 2'b00) xl[n] = 1'b1; m_st[n] = 2'b01; end
               2'b11: begin if (m_st[n] == 2'b01) m_st[n] = 2'b11; end
               default: ;
            endcase
         end
      end
      @(negedge clk);
      bus_wr = w; bus_addr = 8'(32 + 8 * ch); bus_wdata = d; eot_evt = e;
      @(negedge clk);
      bus_wr = 1'b0; eot_evt = 8'h00;
      for (int n = 0; n < 8; n++) begin
         xr[n] = (m_st[n] == 2'b01);
         xp[n] = (m_st[n] == 2'b11);
      end
      chk("R4 load strobe", {8'h00, load_ptr}, {8'h00, xl});
      chk("R5 stop strobe", {8'h00, stop_pulse}, {8'h00, xs});
      chk("R3 running status", {8'h00, ch_running}, {8'h00, xr});
      chk("R3 paused status", {8'h00, ch_paused}, {8'h00, xp});
      @(negedge clk);
      chk("R4 load one cycle", {8'h00, load_ptr}, 16'h0000);
      chk("R5 stop one cycle", {8'h00, stop_pulse}, 16'h0000);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int n = 0; n < 8; n++) begin m_st[n] = 2'b00; m_ord[n] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1, R2: full address sweep at reset
      for (int a = 0; a < 256; a++) begin
         logic [7:0] x;
         bus_addr = 8'(a);
         #1;
         x = 8'h00;
         if (a >= 32 && a < 96 && (a % 8) == 0) x = {4'b0000, DIRM[(a-32)/8], 3'b000};
         chk("R1 R2 reset sweep", {8'h00, bus_rdata}, {8'h00, x});
      end
      chk("R4 reset load", {8'h00, load_ptr}, 16'h0000);
      chk("R3 reset status", {ch_running, ch_paused}, 16'h0000);

      // R3..R9 exhaustive per channel / start state / code / order / eot
      for (int ch = 0; ch < 8; ch++) begin
         for (int st0 = 0; st0 < 3; st0++) begin
            for (int w = 0; w < 2; w++) begin
               for (int code = 0; code < 4; code++) begin
                  for (int ord = 0; ord < 2; ord++) begin
                     for (int ev = 0; ev < 2; ev++) begin
                        logic [7:0] d, e;
                        step(1'b1, ch, 8'h00, 8'h00);
                        if (st0 >= 1) step(1'b1, ch, 8'h01, 8'h00);
                        if (st0 == 2) step(1'b1, ch, 8'h03, 8'h00);
                        d = {4'b1011, ~DIRM[ch], 1'(ord), 2'(code)};
                        e = ev ? 8'(1 << ch) : 8'h00;
                        step(1'(w), ch, d, e);
                        read_all("R8 R6 R7 readback");
                        smp_ch = 3'(ch);
                        smp_in = 16'h5A00 | 16'(ch * 17 + code);
                        #1;
                        chk("R9 sample order", smp_out,
                            m_ord[ch] ? {smp_in[7:0], smp_in[15:8]} : smp_in);
                     end
                  end
               end
            end
         end
      end

      // R8: unmapped writes change nothing
      for (int a = 33; a < 40; a++) begin
         @(negedge clk);
         bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 8'h05;
         @(negedge clk);
         bus_wr = 1'b0;
         chk("R8 unmapped write strobe", {8'h00, load_ptr}, 16'h0000);
      end
      read_all("R8 unmapped write");

      // R7: end-of-table on several running channels at once
      for (int n = 0; n < 8; n++) step(1'b1, n, 8'h01, 8'h00);
      step(1'b0, 0, 8'h00, 8'h99);
      read_all("R7 multi eot");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule